// File: doc/BRIEF.md
# Manchester Line Encoder

This block turns a serial stream of plain level-coded bits into a self-clocking Manchester line signal. It is a Moore state machine clocked at twice the bit rate, so each data bit takes two machine cycles. The first half-bit carries the bit value and the second half-bit carries its complement. The data input is expected to change just after a rising clock edge, in step with the bit clock. The machine updates its state on the falling edge of the double-rate clock. That edge falls in the middle of each half-bit, well away from the moments when the data changes.

There are four one-hot states. One state is the bit boundary reached after a one, and it is also the state after clear. The other three are the low and high halves of a zero and the high half of a one. The line level depends on the state alone. In a second half-bit the data must still hold the value it had in the first half. If it does not, the machine raises a one-cycle error pulse and still moves to its normal successor state, so the line keeps its rhythm.

Top module: `manchesterEncoder`

## Requirements
- R1: While `clear` is high at a falling clock edge, the machine goes to the boundary state: `lineOut` is 0 and `seqErr` is 0 after that edge, and the next bit is encoded from the boundary state.
- R2: A data bit of 1, held for both half-bits, drives `lineOut` to 1 for the first half-bit and to 0 for the second.
- R3: A data bit of 0, held for both half-bits, drives `lineOut` to 0 for the first half-bit and to 1 for the second.
- R4: `lineOut` and `seqErr` change only at falling clock edges. A rising edge leaves them unchanged.
- R5: For every bit, counted in pairs of falling edges after clear is released, the second half-bit level is the opposite of the first. This holds even when an error is flagged.
- R6: If the data is 1 during the second half of a 0 bit, `seqErr` is 1 for the next cycle and `lineOut` still goes high.
- R7: If the data is 0 during the second half of a 1 bit, `seqErr` is 1 for the next cycle and `lineOut` still goes low.
- R8: `seqErr` is 0 whenever the preceding half-bit was legal. It never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; state updates on its falling edge |
| clear | input | 1 | Synchronous clear to the bit-boundary state, sampled on the falling edge |
| dataIn | input | 1 | Serial data bit, held for two clock cycles per bit |
| lineOut | output | 1 | Manchester-coded line level |
| seqErr | output | 1 | One-cycle pulse after a second half-bit saw data opposite to its first half |

## Verification
The assertions assume that `dataIn` is stable around each falling edge. The half-bit pairing check also assumes that bits start on the first falling edge after clear is released, so that edges pair up from that point. The stimulus changes data only just after rising edges and releases clear on a bit boundary. It then sends every 8-bit pattern back to back, followed by directed cases that flip the data between the two halves of a bit and cases that clear partway through a bit.

// File: rtl/manchPkg.sv
package manchPkg;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    ST_BOUND_LO = 4'b0001,
    ST_ZERO_LO  = 4'b0010,
    ST_ZERO_HI  = 4'b0100,
    ST_ONE_HI   = 4'b1000
  } symState_t;

  typedef struct packed {
    logic levelHigh;
    logic seqFault;
  } ctlStrobe_t;
endpackage

// File: rtl/manchCtl.sv
module manchCtl
  import manchPkg::*;
(
  input  logic                clk,
  input  logic                clear,
  input  logic                dataIn,
  output logic [STATE_W-1:0]  stateQ,
  output ctlStrobe_t          strobe
);
  symState_t curState, nextState;
  logic      badInput;

  always_comb begin
    nextState = ST_BOUND_LO;
    badInput  = 1'b0;
    unique case (curState)
      ST_BOUND_LO, ST_ZERO_HI: nextState = dataIn ? ST_ONE_HI : ST_ZERO_LO;
      ST_ZERO_LO: begin
        nextState = ST_ZERO_HI;
        badInput  = dataIn;
      end
      ST_ONE_HI: begin
        nextState = ST_BOUND_LO;
        badInput  = ~dataIn;
      end
      default: nextState = ST_BOUND_LO;
    endcase
  end

  always_ff @(negedge clk) begin
    if (clear) curState <= ST_BOUND_LO;
    else       curState <= nextState;
  end

  always_comb begin
    strobe.levelHigh = (curState == ST_ZERO_HI) || (curState == ST_ONE_HI);
    strobe.seqFault  = badInput & ~clear;
  end

  assign stateQ = curState;
endmodule

// File: rtl/manchDp.sv
module manchDp
  import manchPkg::*;
(
  input  logic       clk,
  input  logic       clear,
  input  ctlStrobe_t strobe,
  output logic       lineOut,
  output logic       errFlag
);
  always_ff @(negedge clk) begin
    if (clear) errFlag <= 1'b0;
    else       errFlag <= strobe.seqFault;
  end

  assign lineOut = strobe.levelHigh;
endmodule

// File: rtl/manchesterEncoder.sv
module manchesterEncoder
  import manchPkg::*;
(
  input  logic clk,
  input  logic clear,
  input  logic dataIn,
  output logic lineOut,
  output logic seqErr
);
  logic [STATE_W-1:0] stateQ;
  ctlStrobe_t         ctlBus;

  manchCtl u_ctl (
    .clk    (clk),
    .clear  (clear),
    .dataIn (dataIn),
    .stateQ (stateQ),
    .strobe (ctlBus)
  );

  manchDp u_dp (
    .clk     (clk),
    .clear   (clear),
    .strobe  (ctlBus),
    .lineOut (lineOut),
    .errFlag (seqErr)
  );
endmodule

// File: rtl/manchesterEncoderChk.sv
module manchesterEncoderChk
  import manchPkg::*;
(
  input logic               clk,
  input logic               clear,
  input logic               dataIn,
  input logic [STATE_W-1:0] stateQ,
  input logic               lineOut,
  input logic               seqErr
);
  logic halfPhase;
  logic started;

  always_ff @(negedge clk) begin
    if (clear) begin
      halfPhase <= 1'b0;
      started   <= 1'b0;
    end else begin
      halfPhase <= ~halfPhase;
      started   <= 1'b1;
    end
  end

  a_r2_one_starts_high: assert property (@(negedge clk) disable iff (clear)
    ((stateQ == ST_BOUND_LO || stateQ == ST_ZERO_HI) && dataIn) |=> lineOut);

  a_r3_zero_starts_low: assert property (@(negedge clk) disable iff (clear)
    ((stateQ == ST_BOUND_LO || stateQ == ST_ZERO_HI) && !dataIn) |=> !lineOut);

  a_r5_halves_opposite: assert property (@(negedge clk) disable iff (clear)
    (started && !halfPhase) |-> (lineOut != $past(lineOut)));

  a_r6_fault_in_zero: assert property (@(negedge clk) disable iff (clear)
    (stateQ == ST_ZERO_LO && dataIn) |=> (seqErr && lineOut));

  a_r7_fault_in_one: assert property (@(negedge clk) disable iff (clear)
    (stateQ == ST_ONE_HI && !dataIn) |=> (seqErr && !lineOut));

  a_r8_single_pulse: assert property (@(negedge clk) disable iff (clear)
    seqErr |=> !seqErr);
endmodule

bind manchesterEncoder manchesterEncoderChk u_chk (
  .clk     (clk),
  .clear   (clear),
  .dataIn  (dataIn),
  .stateQ  (stateQ),
  .lineOut (lineOut),
  .seqErr  (seqErr)
);

// File: tb/manchesterEncoder_bench.sv
module manchesterEncoder_bench;
  logic clk = 1'b1;
  logic clear = 1'b1;
  logic dataIn = 1'b0;
  logic lineOut, seqErr;
  int   errors = 0;
  int   checks = 0;
  bit   done = 0;

  always #2 clk = ~clk;

  manchesterEncoder u_manchesterEncoder (
    .clk     (clk),
    .clear   (clear),
    .dataIn  (dataIn),
    .lineOut (lineOut),
    .seqErr  (seqErr)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Called just after a rising edge; returns just after a later rising edge.
  task automatic sendBit(input logic b, input logic flip);
    logic atFall;
    dataIn = b;
    @(negedge clk); #1;
    atFall = lineOut;
    @(posedge clk); #1;
    chk("R4 level kept over rising edge", lineOut, atFall);
    chk(b ? "R2 first half of one" : "R3 first half of zero", lineOut, b);
    chk("R8 no error after legal half", seqErr, 1'b0);
    if (flip) dataIn = ~b;
    @(negedge clk); #1;
    atFall = lineOut;
    @(posedge clk); #1;
    chk("R4 level kept over rising edge", lineOut, atFall);
    chk(flip ? (b ? "R7 line low after fault" : "R6 line high after fault")
             : (b ? "R2 second half of one" : "R3 second half of zero"),
        lineOut, ~b);
    chk(flip ? (b ? "R7 error pulse" : "R6 error pulse") : "R8 no error on legal bit",
        seqErr, flip);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    @(posedge clk); #1;
    chk("R1 line low in clear", lineOut, 1'b0);
    chk("R1 error low in clear", seqErr, 1'b0);
    clear = 1'b0;

    // R2 R3 R5: every 8-bit pattern, streamed without gaps
    for (int p = 0; p < 256; p++)
      for (int i = 7; i >= 0; i--)
        sendBit(p[i], 1'b0);

    // R6 R7 R8: faults from both states, back to back and separated
    sendBit(1'b0, 1'b1);
    sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b1);
    sendBit(1'b1, 1'b0);
    sendBit(1'b0, 1'b1);
    sendBit(1'b1, 1'b1);
    sendBit(1'b0, 1'b1);
    sendBit(1'b0, 1'b0);

    // R1: clear in the middle of a one, then a zero encodes from boundary
    dataIn = 1'b1;
    @(negedge clk); @(posedge clk); #1;
    chk("R2 high before mid-bit clear", lineOut, 1'b1);
    clear = 1'b1;
    @(negedge clk); @(posedge clk); #1;
    chk("R1 line low after clear", lineOut, 1'b0);
    chk("R1 error low after clear", seqErr, 1'b0);
    clear = 1'b0;
    sendBit(1'b0, 1'b0);
    sendBit(1'b1, 1'b0);

    // R1: clear while a fault is pending suppresses the pulse
    dataIn = 1'b0;
    @(negedge clk); @(posedge clk); #1;
    dataIn = 1'b1;
    clear = 1'b1;
    @(negedge clk); @(posedge clk); #1;
    chk("R1 clear overrides fault", seqErr, 1'b0);
    chk("R1 line low after clear", lineOut, 1'b0);
    clear = 1'b0;
    sendBit(1'b1, 1'b0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule